// File: doc/BRIEF.md
# Event Timestamp Capture Queues with Interrupts

The block records when precision-time event frames cross the port. A frame parser outside the block pulses one strobe per event frame, one strobe for the receive (ingress) path and one for the transmit (egress) path, together with that frame's 16-bit sequence number. At that clock edge the block stores the free-running time value on its inputs (32-bit seconds, 30-bit nanoseconds) and the sequence number as one entry in the queue for that direction. Each direction has its own first-in first-out queue of `DEPTH` entries.

Software reads the oldest entry of a queue through five 16-bit register words. The valid flag is in the top bit of the nanoseconds-high word. Reading the sequence word removes the entry, so a driver reads words until the valid flag is 0. Interrupt status bits mark "timestamp available" and "capture lost" for each direction. Each bit is gated by an enable bit, and the gated bits combine into one summary interrupt. The event strobes have no back-pressure. A capture that finds its queue full is discarded and recorded as an overflow. The register port has no handshake either: every read and write completes in one cycle.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset both queues are empty. The status register, the enable register and the top-level enable read 0, and `irq` is low.
- R2: An `ing_evt` or `egr_evt` pulse stores {`cur_sec`, `cur_ns`, sequence} from that clock edge in the queue of that direction only. Both directions may capture in the same cycle.
- R3: Word addresses for ingress are 0 to 4 and for egress 8 to 12, in this order: nanoseconds-high, nanoseconds-low, seconds-high, seconds-low, sequence. Nanoseconds-high reads {valid at bit 15, 0 at bit 14, ns[29:16] in bits 13:0}. Nanoseconds-low reads ns[15:0]. Seconds-high reads sec[31:16] and seconds-low reads sec[15:0].
- R4: Reading the sequence word of a non-empty queue pops its oldest entry. Entries come out in capture order.
- R5: An empty queue reads 0x0000 at its nanoseconds-high word. Reading the sequence word of an empty queue leaves the queue unchanged.
- R6: A capture that arrives while its queue is full, with no pop in the same cycle, is dropped. The stored entries are kept, and the overflow status bit is set: bit 13 for egress, bit 9 for ingress.
- R7: Every accepted capture sets the timestamp-available status bit: bit 12 for egress, bit 8 for ingress.
- R8: The status register (address 5) returns its value and clears on read. A timestamp-available bit is set again at once if its queue still holds entries. A bit set by an event in the same cycle as the read is not lost.
- R9: The enable register (address 6, same bit positions) gates the status bits, and any enabled status bit raises the summary. Top-level status (address 13) shows the summary at bit 9. Top-level enable (address 14) bit 9 gates it onto `irq`.
- R10: A read returns its data on `rd_data` one clock after `rd_en`. `rd_data` holds its value in cycles without a read.
- R11: `DEPTH` reads of a queue's sequence word empty that queue completely, from any fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sec | input | 32 | Current time, seconds |
| cur_ns | input | 30 | Current time, nanoseconds |
| ing_evt | input | 1 | Ingress event frame strobe |
| ing_seq | input | 16 | Ingress frame sequence number |
| egr_evt | input | 1 | Egress event frame strobe |
| egr_seq | input | 16 | Egress frame sequence number |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Registered read data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| irq | output | 1 | Summary interrupt |

## Verification
The bench overfills the egress queue by three captures. A design that overwrote old entries or kept the late ones would return the wrong sequence numbers and time values during the drain. One that dropped silently would leave bit 13 clear. It reads the status register twice while entries remain and again after the drain. A plain clear-on-read design would lose the second timestamp-available indication, and a sticky one would never clear. It also pops an empty queue before a capture, sends captures in both directions in the same cycle, and flushes with exactly `DEPTH` pops. An underflow or a shared pointer would show up there as a wrong head entry or as a valid flag still set. The enable registers are tested with the summary on while the pin is masked, which catches a wrong gating order.

// File: rtl/ptp_tsq_pkg.sv
package ptp_tsq_pkg;
  parameter int SEC_W  = 32;
  parameter int NS_W   = 30;
  parameter int SEQ_W  = 16;
  parameter int WORD_W = 16;
  parameter int ADDR_W = 4;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [SEQ_W-1:0] seq;
  } ts_entry_t;

  // word index inside one direction's window
  localparam logic [2:0] W_NS_HI  = 3'd0;
  localparam logic [2:0] W_NS_LO  = 3'd1;
  localparam logic [2:0] W_SEC_HI = 3'd2;
  localparam logic [2:0] W_SEC_LO = 3'd3;
  localparam logic [2:0] W_SEQ    = 3'd4;

  localparam logic [ADDR_W-1:0] A_INT_STS = 4'd5;
  localparam logic [ADDR_W-1:0] A_INT_EN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_TOP_STS = 4'd13;
  localparam logic [ADDR_W-1:0] A_TOP_EN  = 4'd14;

  // status bit positions: [dir] -> bit
  localparam int B_TS0  = 8;
  localparam int B_OVF0 = 9;
  localparam int B_TS1  = 12;
  localparam int B_OVF1 = 13;
  localparam int B_TOP  = 9;
  localparam logic [WORD_W-1:0] STS_MASK =
    WORD_W'((1 << B_TS0) | (1 << B_OVF0) | (1 << B_TS1) | (1 << B_OVF1));
  localparam logic [WORD_W-1:0] TOP_MASK = WORD_W'(1 << B_TOP);
endpackage

// File: rtl/ts_fifo.sv
module ts_fifo
  import ptp_tsq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  ts_entry_t push_data,
  input  logic      pop,
  output ts_entry_t head,
  output logic      empty,
  output logic      accepted,
  output logic      dropped
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  ts_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, pop_ok;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign pop_ok   = pop & ~empty;
  assign accepted = push & (~full | pop_ok);
  assign dropped  = push & full & ~pop_ok;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accepted) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(accepted) - CNT_W'(pop_ok);
    end
  end

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R6
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> (count == CNT_W'(DEPTH)));
  // R5
  empty_pop_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
  // R2
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> !empty);
endmodule

// File: rtl/ts_irq.sv
module ts_irq
  import ptp_tsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ts_set,
  input  logic [1:0]        ovf_set,
  input  logic [1:0]        nonempty,
  input  logic              sts_rd,
  input  logic              en_wr,
  input  logic              top_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] sts_word,
  output logic [WORD_W-1:0] en_word,
  output logic [WORD_W-1:0] top_en_word,
  output logic              summary,
  output logic              irq
);
  logic [1:0] ts_q, ovf_q;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ts_q[d]  <= 1'b0;
        ovf_q[d] <= 1'b0;
      end else begin
        ts_q[d]  <= (ts_q[d] & ~sts_rd) | ts_set[d] | (sts_rd & nonempty[d]);
        ovf_q[d] <= (ovf_q[d] & ~sts_rd) | ovf_set[d];
      end
    end

    // R8
    ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && !nonempty[d] && !ts_set[d]) |=> !ts_q[d]);
    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[d]) |-> $past(ovf_set[d]));
  end

  always_comb begin
    sts_word         = '0;
    sts_word[B_TS0]  = ts_q[0];
    sts_word[B_OVF0] = ovf_q[0];
    sts_word[B_TS1]  = ts_q[1];
    sts_word[B_OVF1] = ovf_q[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_word     <= '0;
      top_en_word <= '0;
    end else begin
      if (en_wr)  en_word     <= wdata & STS_MASK;
      if (top_wr) top_en_word <= wdata & TOP_MASK;
    end
  end

  assign summary = |(sts_word & en_word);
  assign irq     = summary & top_en_word[B_TOP];

  // R9
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ts_q != 2'b00) || (ovf_q != 2'b00)));
endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
  import ptp_tsq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [NS_W-1:0]   cur_ns,
  input  logic              ing_evt,
  input  logic [SEQ_W-1:0]  ing_seq,
  input  logic              egr_evt,
  input  logic [SEQ_W-1:0]  egr_seq,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              irq
);
  logic [1:0]       evt, pop, empty, acc, drop;
  logic [SEQ_W-1:0] seq_in [2];
  ts_entry_t        head   [2];
  logic [WORD_W-1:0] win   [2];
  logic [WORD_W-1:0] sts_word, en_word, top_en_word, rd_mux;
  logic              summary, sts_rd;

  assign evt       = {egr_evt, ing_evt};
  assign seq_in[0] = ing_seq;
  assign seq_in[1] = egr_seq;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic sel;
    assign sel    = (rd_addr[ADDR_W-1] == 1'(d));
    assign pop[d] = rd_en & sel & (rd_addr[2:0] == W_SEQ);

    ts_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (evt[d]),
      .push_data('{sec: cur_sec, ns: cur_ns, seq: seq_in[d]}),
      .pop      (pop[d]),
      .head     (head[d]),
      .empty    (empty[d]),
      .accepted (acc[d]),
      .dropped  (drop[d])
    );

    always_comb begin
      unique case (rd_addr[2:0])
        W_NS_HI:  win[d] = empty[d] ? '0
                         : {1'b1, (WORD_W-1)'(head[d].ns >> WORD_W)};
        W_NS_LO:  win[d] = head[d].ns[WORD_W-1:0];
        W_SEC_HI: win[d] = WORD_W'(head[d].sec >> WORD_W);
        W_SEC_LO: win[d] = head[d].sec[WORD_W-1:0];
        W_SEQ:    win[d] = WORD_W'(head[d].seq);
        default:  win[d] = '0;
      endcase
    end
  end

  assign sts_rd = rd_en & (rd_addr == A_INT_STS);

  ts_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_set     (acc),
    .ovf_set    (drop),
    .nonempty   (~empty),
    .sts_rd     (sts_rd),
    .en_wr      (wr_en & (wr_addr == A_INT_EN)),
    .top_wr     (wr_en & (wr_addr == A_TOP_EN)),
    .wdata      (wr_data),
    .sts_word   (sts_word),
    .en_word    (en_word),
    .top_en_word(top_en_word),
    .summary    (summary),
    .irq        (irq)
  );

  always_comb begin
    unique case (rd_addr)
      A_INT_STS: rd_mux = sts_word;
      A_INT_EN:  rd_mux = en_word;
      A_TOP_STS: rd_mux = WORD_W'(summary) << B_TOP;
      A_TOP_EN:  rd_mux = top_en_word;
      default:   rd_mux = win[rd_addr[ADDR_W-1]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R5
  empty_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == {1'b0, W_NS_HI} && empty[0]) |=> (rd_data == '0));
  // R3
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == {1'b1, W_NS_HI} && !empty[1]) |=> rd_data[WORD_W-1]);
endmodule

// File: tb/tb_ptp_ts_capture.sv
module tb_ptp_ts_capture;
  import ptp_tsq_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SEC_W-1:0] cur_sec = '0;
  logic [NS_W-1:0]  cur_ns = '0;
  logic ing_evt = 1'b0, egr_evt = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [SEQ_W-1:0] ing_seq = '0, egr_seq = '0;
  logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0, rd_data;
  logic irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  ts_entry_t sb_q [2][$];

  always #4 clk = ~clk;

  ptp_ts_capture #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // driver: records expected entries in the scoreboard as it drives
  task automatic capture(bit both, int d, logic [31:0] s, logic [29:0] n, logic [15:0] q);
    @(negedge clk);
    cur_sec = s; cur_ns = n;
    for (int k = 0; k < 2; k++) begin
      if (both || k == d) begin
        if (k == 0) begin ing_evt = 1'b1; ing_seq = q; end
        else        begin egr_evt = 1'b1; egr_seq = q ^ 16'h8000; end
        if (sb_q[k].size() < DEPTH)
          sb_q[k].push_back('{sec: s, ns: n, seq: (k == 0) ? q : (q ^ 16'h8000)});
      end
    end
    @(negedge clk);
    ing_evt = 1'b0; egr_evt = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: drain until invalid, comparing each entry with the scoreboard
  task automatic drain(int d, int exp_n);
    logic [15:0] w0, w1, w2, w3, w4;
    int n = 0;
    logic [3:0] base = (d == 1) ? 4'd8 : 4'd0;
    bit stop = 1'b0;
    while (!stop && n < DEPTH + 2) begin
      rd(base + 4'd0, w0);
      if (!w0[15]) stop = 1'b1;
      else begin
        ts_entry_t e;
        rd(base + 4'd1, w1); rd(base + 4'd2, w2); rd(base + 4'd3, w3);
        rd(base + 4'd4, w4);
        e = (sb_q[d].size() != 0) ? sb_q[d].pop_front() : '0;
        chk("R3 ns_hi", {16'h0, w0}, {16'h0, 2'b10, e.ns[29:16]});
        chk("R3 ns_lo", {16'h0, w1}, {16'h0, e.ns[15:0]});
        chk("R3 sec", {w2, w3}, e.sec);
        chk("R4 seq order", {16'h0, w4}, {16'h0, e.seq});
        n++;
      end
    end
    chk("R4/R6 entry count", n, exp_n);
    chk("R5 drained valid=0", {16'h0, w0}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v);  chk("R1 ingress empty", v, 0);
    rd(4'd8, v);  chk("R1 egress empty", v, 0);
    rd(4'd5, v);  chk("R1 status", v, 0);
    rd(4'd6, v);  chk("R1 enable", v, 0);
    rd(4'd14, v); chk("R1 top enable", v, 0);
    chk("R1 irq", irq, 0);

    wr(4'd6, 16'h3300);
    wr(4'd14, 16'h0200);

    // R2/R7 ingress captures
    for (int i = 0; i < 3; i++)
      capture(0, 0, 32'hA000_1000 + i * 32'h0001_0003, 30'h2ABC_1234 + i * 30'h77, 16'h0100 + 16'(i));
    @(negedge clk);
    chk("R9 irq raised", irq, 1);
    rd(4'd13, v); chk("R9 top status bit9", v, 16'h0200);
    rd(4'd8, v);  chk("R2 egress untouched", v, 0);
    rd(4'd5, v);  chk("R7 ingress ts bit8", v, 16'h0100);
    rd(4'd5, v);  chk("R8 re-set while entries remain", v, 16'h0100);
    drain(0, 3);
    rd(4'd5, v);  chk("R8 read after drain", v, 16'h0100);
    rd(4'd5, v);  chk("R8 cleared when empty", v, 16'h0000);
    @(negedge clk);
    chk("R9 irq dropped", irq, 0);

    // R6 egress overflow
    for (int i = 0; i < DEPTH + 3; i++)
      capture(0, 1, 32'h0000_5000 + 32'(i * 7), 30'h0001_0000 * 30'(i) + 30'(i), 16'h0200 + 16'(i));
    rd(4'd5, v);  chk("R6/R7 egress overflow+ts", v, 16'h3000);
    rd(4'd0, v);  chk("R2 ingress still empty", v, 0);
    drain(1, DEPTH);

    // R5 pop of empty queue is ignored
    rd(4'd4, v);
    capture(0, 0, 32'hDEAD_0001, 30'h0000_0042, 16'h0BEE);
    rd(4'd4, v);  chk("R5 empty pop ignored, head seq", v, 16'h0BEE);
    void'(sb_q[0].pop_front());

    // R2 simultaneous captures, then R11 flush
    rd(4'd5, v);
    for (int i = 0; i < 3; i++)
      capture(1, 0, 32'h7777_0000 + 32'(i), 30'h1000_0000 + 30'(i), 16'h0300 + 16'(i));
    rd(4'd5, v);  chk("R2 both directions ts", v, 16'h1100);
    for (int i = 0; i < DEPTH; i++) rd(4'd4, v);
    rd(4'd0, v);  chk("R11 flush ingress", v, 0);
    sb_q[0].delete();
    drain(1, 3);

    // R9 gating
    rd(4'd5, v);
    wr(4'd6, 16'h0000);
    capture(0, 0, 32'h1, 30'h2, 16'h0400);
    @(negedge clk);
    chk("R9 masked by enable", irq, 0);
    rd(4'd13, v); chk("R9 summary off", v, 0);
    wr(4'd6, 16'h0100);
    @(negedge clk);
    chk("R9 enable bit8", irq, 1);
    wr(4'd14, 16'h0000);
    @(negedge clk);
    chk("R9 top enable masks pin", irq, 0);
    rd(4'd13, v); chk("R9 summary still set", v, 16'h0200);

    // R10 hold without read
    rd(4'd6, v);
    capture(0, 0, 32'h2, 30'h3, 16'h0401);
    repeat (3) @(negedge clk);
    chk("R10 rd_data held", rd_data, 16'h0100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule